// File: doc/BRIEF.md
# Buffered factory-program command engine

This block is the device-side control of a NOR-style flash array for one fast production-programming command. A host starts it with two bus writes, a setup opcode and a confirm opcode. The confirm address names the target block and the first word to be programmed. The engine then collects data words into a 32-word write buffer. When the buffer is full it commits the buffer to the array and starts collecting the next 32 words. It leaves the mode when the host writes to an address outside the target block.

Any write whose address falls inside the target block is data, even when its value equals a command opcode. Programming only clears bits: each word is stored as the old contents ANDed with the new data. As long as no error is present, status is returned on every read from the confirm onward. An error flag reports a locked or misaligned target and a bad confirm. A sticky sequence flag reports writes that arrive while a buffer commit is running, and writes that arrive after the block is full.

Top module: `fbp_engine`

## Requirements
- R1: After reset the engine reads the array. Every word reads 0xFFFF, the erased value.
- R2: A write whose low byte is 0x80, followed by a write whose low byte is 0xD0 to an aligned address in an unlocked block, enters the load phase. From then on a read at any address returns status, with bit 7 (ready) at 0 while loading or committing.
- R3: Within the load phase, each write to any address inside the target block supplies the next data word. The words go in order to consecutive locations starting at the confirm address.
- R4: After the 32nd word, status bit 0 (commit busy) is 1 for exactly PROG_CYC cycles. The array is then updated, and each word becomes its old value ANDed with the written data.
- R5: In-block data words equal to the opcode bytes 0x70, 0xB0, 0xD0 and 0x80 are programmed as data.
- R6: If the confirm address is not on a 32-word boundary (low five address bits not zero), status bit 4 (error) is set, bit 7 returns to 1 and the array is unchanged.
- R7: If the confirm address lies in a block whose lock_mask bit is 1, status bit 4 is set and the array is unchanged.
- R8: If the write after setup does not carry 0xD0, status bits 4 and 5 are set and the engine returns to status reads.
- R9: After a commit, the next 32 in-block writes fill the following 32 locations without a new setup.
- R10: An out-of-block write during loading leaves the mode and sets status bit 7. Words of a partly filled buffer are discarded.
- R11: A write during a commit is ignored and sets sticky status bit 5. The next buffer still starts with its first word.
- R12: Once the whole block has been committed, further in-block writes are ignored and set status bit 5.
- R13: While reads return status after an exit or error, a setup write starts a new setup and clears bits 4 and 5. Any other write returns the engine to array reads.
- R14: While reading the array, any write that is not the setup opcode has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Bus write strobe, sampled on the rising clock edge |
| wr_addr | input | AW | Bus write word address |
| wr_data | input | DW | Bus write data or command (opcode in the low byte) |
| rd_addr | input | AW | Bus read word address |
| lock_mask | input | 2**(AW-BLK_W) | One lock bit per block, 1 means locked |
| rd_data | output | DW | Array word in array-read state, otherwise status in the low byte |

## Verification
The bench builds the engine with a 1024-word array split into four 256-word blocks, a 32-word buffer and a six-cycle commit. With this configuration one block fills in eight buffers. The bench can therefore reach the block-full condition, reprogram a block over itself, and compare every word of the array against an arithmetic model after each session. Block 2 is locked through lock_mask, so the lock abort can be compared against unlocked blocks in the same run.

// File: rtl/fbp_engine.sv
`timescale 1ns/1ps
module fbp_engine #(
  parameter int AW = 10,
  parameter int DW = 16,
  parameter int BLK_W = 8,
  parameter int BUF = 32,
  parameter int PROG_CYC = 6,
  parameter logic [7:0] SETUP_OP = 8'h80,
  parameter logic [7:0] CONFIRM_OP = 8'hD0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [DW-1:0]             wr_data,
  input  logic [AW-1:0]             rd_addr,
  input  logic [(1<<(AW-BLK_W))-1:0] lock_mask,
  output logic [DW-1:0]             rd_data
);
  localparam int DEPTH = 1 << AW;
  localparam int BW = $clog2(BUF);
  localparam int CW = $clog2(PROG_CYC + 1);
  localparam int NW = AW - BLK_W;
  localparam logic [BW-1:0] LAST = BW'(BUF - 1);

  typedef enum logic [2:0] {IDLE, SETUP, LOAD, PROG, STAT} st_t;

  st_t            st;
  logic [DW-1:0]  mem  [DEPTH];
  logic [DW-1:0]  wbuf [BUF];
  logic [NW-1:0]  blk;
  logic [AW-1:0]  base;
  logic [BW-1:0]  widx;
  logic [CW-1:0]  cnt;
  logic           err, seq, full;
  logic [7:0]     stat;

  wire [NW-1:0] wblk    = wr_addr[AW-1:BLK_W];
  wire          in_blk  = (wblk == blk);
  wire          op_set  = (wr_data[7:0] == SETUP_OP);
  wire          op_conf = (wr_data[7:0] == CONFIRM_OP);
  wire          aligned = (wr_addr[BW-1:0] == '0);
  wire          locked  = lock_mask[wblk];

  assign stat = {~(st == LOAD || st == PROG), 1'b0, seq, err, 3'b000, st == PROG};
  assign rd_data = (st == IDLE) ? mem[rd_addr] : DW'(stat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= IDLE;
      blk  <= '0;
      base <= '0;
      widx <= '0;
      cnt  <= '0;
      err  <= 1'b0;
      seq  <= 1'b0;
      full <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      for (int i = 0; i < BUF; i++) wbuf[i] <= '1;
    end else begin
      case (st)
        IDLE: if (wr_en && op_set) begin
          st  <= SETUP;
          err <= 1'b0;
          seq <= 1'b0;
        end
        SETUP: if (wr_en) begin
          if (!op_conf) begin
            err <= 1'b1;
            seq <= 1'b1;
            st  <= STAT;
          end else if (locked || !aligned) begin
            err <= 1'b1;
            st  <= STAT;
          end else begin
            blk  <= wblk;
            base <= wr_addr;
            widx <= '0;
            full <= 1'b0;
            st   <= LOAD;
          end
        end
        LOAD: if (wr_en) begin
          if (!in_blk) st <= STAT;
          else if (full) seq <= 1'b1;
          else begin
            wbuf[widx] <= wr_data;
            widx <= widx + 1'b1;
            if (widx == LAST) begin
              st  <= PROG;
              cnt <= CW'(PROG_CYC - 1);
            end
          end
        end
        PROG: begin
          if (wr_en) seq <= 1'b1;
          if (cnt == '0) begin
            for (int i = 0; i < BUF; i++)
              mem[base + AW'(i)] <= mem[base + AW'(i)] & wbuf[i];
            base <= base + AW'(BUF);
            full <= &base[BLK_W-1:BW];
            st   <= LOAD;
          end else cnt <= cnt - 1'b1;
        end
        STAT: if (wr_en) begin
          if (op_set) begin
            st  <= SETUP;
            err <= 1'b0;
            seq <= 1'b0;
          end else st <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R2
  entry_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SETUP && wr_en && op_conf && !locked && aligned) |=> (st == LOAD && !rd_data[7]));
  // R4
  commit_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PROG && cnt == '0) |=> (st == LOAD && widx == '0));
  // R7
  lock_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SETUP && wr_en && op_conf && locked) |=> (st == STAT && err));
  // R10
  exit_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LOAD && wr_en && !in_blk) |=> (st == STAT && rd_data[7]));
  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PROG && wr_en) |=> (seq && widx == '0));
endmodule

// File: tb/fbp_engine_bench.sv
`timescale 1ns/1ps
module fbp_engine_bench;
  localparam int AW = 10, DW = 16, BLK_W = 8, BUF = 32, PROG_CYC = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [3:0] lock_mask = 4'b0100;
  logic [DW-1:0] rd_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [DW-1:0] exp_mem [DEPTH];
  logic [DW-1:0] exp_buf [BUF];

  always #5 clk = ~clk;

  fbp_engine #(.AW(AW), .DW(DW), .BLK_W(BLK_W), .BUF(BUF), .PROG_CYC(PROG_CYC)) u_fbp_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .lock_mask(lock_mask), .rd_data(rd_data));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic get_rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic compare_all(input string tag);
    logic [DW-1:0] v;
    for (int a = 0; a < DEPTH; a++) begin
      get_rd(AW'(a), v);
      check(tag, v, exp_mem[a]);
    end
  endtask

  // seed 0: constant 0xFF00; special: opcode bytes at offsets 3..6
  task automatic load_buf(input int base, input int seed, input bit special, input bit poke);
    logic [DW-1:0] v;
    logic [7:0] ops [4];
    int bstart;
    int n;
    ops[0] = 8'h70; ops[1] = 8'hB0; ops[2] = 8'hD0; ops[3] = 8'h80;
    bstart = base & ~((1 << BLK_W) - 1);
    for (int i = 0; i < BUF; i++) begin
      logic [DW-1:0] d;
      if (seed == 0) d = 16'hFF00;
      else d = 16'(((base + i) * 40503) ^ (seed * 497));
      if (special && i >= 3 && i <= 6) d = {8'h00, ops[i-3]};
      exp_buf[i] = d;
      wr(AW'(bstart + ((i * 7 + seed) & ((1 << BLK_W) - 1))), d);
    end
    if (poke) wr(AW'(bstart + 5), 16'h1234);
    n = 0;
    get_rd(0, v);
    check("R2 ready low while committing", 32'(v[7]), 0);
    while (v[0]) begin
      n++;
      @(negedge clk);
      get_rd(0, v);
    end
    if (!poke) check("R4 busy cycle count", n, PROG_CYC);
    for (int i = 0; i < BUF; i++) exp_mem[base + i] = exp_mem[base + i] & exp_buf[i];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    for (int a = 0; a < DEPTH; a++) exp_mem[a] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare_all("R1");

    wr(10'd5, 16'h0000);
    wr(10'd6, 16'h00D0);
    get_rd(10'd5, v); check("R14 idle write ignored", v, 16'hFFFF);
    get_rd(10'd6, v); check("R14 idle write ignored", v, 16'hFFFF);

    // full block 1
    wr(10'h3FF, 16'h0080);
    get_rd(10'h000, v); check("R13 setup status", v, 16'h0080);
    wr(10'h100, 16'h00D0);
    get_rd(10'h2AA, v); check("R2 load status", v, 16'h0000);
    for (int b = 0; b < 8; b++) load_buf(32'h100 + 32 * b, b + 1, b == 0, 1'b0);
    get_rd(10'h000, v); check("R9 status after eight buffers", v, 16'h0000);
    wr(10'h1AB, 16'h0000);
    get_rd(10'h000, v); check("R12 full block write flagged", v, 16'h0020);
    wr(10'h000, 16'h1111);
    get_rd(10'h000, v); check("R10 exit status", v, 16'h00A0);
    wr(10'h000, 16'h00FF);
    compare_all("R3 R9 R12");
    get_rd(10'h103, v); check("R5 opcode 70 as data", v, 16'h0070);
    get_rd(10'h104, v); check("R5 opcode B0 as data", v, 16'h00B0);
    get_rd(10'h105, v); check("R5 opcode D0 as data", v, 16'h00D0);
    get_rd(10'h106, v); check("R5 opcode 80 as data", v, 16'h0080);

    // reprogram over programmed words
    wr(10'h000, 16'h0080);
    wr(10'h100, 16'h00D0);
    load_buf(32'h100, 0, 1'b0, 1'b0);
    wr(10'h000, 16'h0000);
    get_rd(10'h000, v); check("R10 exit status clean", v, 16'h0080);
    wr(10'h000, 16'h00FF);
    compare_all("R4 AND programming");

    // partial buffer then exit
    wr(10'h000, 16'h0080);
    wr(10'h000, 16'h00D0);
    for (int i = 0; i < 10; i++) wr(10'h000, 16'h0000);
    wr(10'h300, 16'h0000);
    get_rd(10'h000, v); check("R10 partial exit", v, 16'h0080);
    wr(10'h000, 16'h00FF);
    compare_all("R10 partial discarded");

    // misaligned
    wr(10'h000, 16'h0080);
    wr(10'h010, 16'h00D0);
    get_rd(10'h000, v); check("R6 misaligned error", v, 16'h0090);
    wr(10'h010, 16'h0000);
    compare_all("R6 R13");

    // locked block 2
    wr(10'h000, 16'h0080);
    wr(10'h200, 16'h00D0);
    get_rd(10'h000, v); check("R7 locked error", v, 16'h0090);
    wr(10'h200, 16'h0000);
    compare_all("R7");

    // bad confirm, then new setup from status state
    wr(10'h000, 16'h0080);
    wr(10'h300, 16'h0055);
    get_rd(10'h000, v); check("R8 bad confirm", v, 16'h00B0);
    wr(10'h000, 16'h0080);
    get_rd(10'h000, v); check("R13 new setup clears errors", v, 16'h0080);
    wr(10'h300, 16'h00D0);
    get_rd(10'h000, v); check("R2 block 3 load", v, 16'h0000);
    load_buf(32'h300, 30, 1'b0, 1'b1);
    get_rd(10'h000, v); check("R11 busy write flagged", v, 16'h0020);
    load_buf(32'h320, 31, 1'b0, 1'b0);
    wr(10'h000, 16'h0000);
    get_rd(10'h000, v); check("R11 exit with sticky flag", v, 16'h00A0);
    wr(10'h000, 16'h00FF);
    compare_all("R11");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule